// File: doc/BRIEF.md
# DMA Channel Transfer Counters

This block keeps the counting state of a single DMA channel. It holds a 32-bit byte count and a 32-bit block register. The upper half of the block register is a fixed reload size and the lower half is a running counter. The channel engine pulses a strobe for every completed transfer, giving the unit size and the transfer mode. The block then updates both registers. It raises a one-cycle pulse when the byte count runs out and another when a block boundary is crossed. It also holds a stop flag until the CPU clears it.

The CPU reads both registers from the outputs and writes them through a 16-bit-granular write port. A byte count of zero means the channel is not counting, so it runs without limit. When a CPU write and a transfer update land in the same cycle, the CPU value is stored. A transfer that would have exhausted the count still stops the channel in that case.

Top module: `dma_xfer_counters`

## Requirements
- R1: On `xfer_vld` with a nonzero count larger than the step, the byte count drops by the step: 1 for unit code 00 (byte), 2 for 01 (word), 4 for 10 (longword), and 4 for the reserved code 11.
- R2: A transfer that finds the byte count at 0 leaves it at 0. It raises no end pulse and does not set the stop flag.
- R3: A CPU write to a register in the same cycle as a transfer update of that register stores the CPU value, and the transfer update of that register is discarded.
- R4: When a transfer takes a nonzero count to 0 in the same cycle as a CPU write to the count, the written value is stored. The stop flag is still set and the end pulse is still raised.
- R5: Mode code 00 (normal), and the reserved code 11, leave the block register unchanged on a transfer. Code 01 is block mode and code 10 is repeat mode.
- R6: In block or repeat mode, a transfer never changes bits 31:16 of the block register and decreases bits 15:0 by 1 when they are above 1.
- R7: In block or repeat mode, a transfer that finds bits 15:0 at 1 or 0 loads them from bits 31:16 and raises `blk_pulse` for exactly the next cycle.
- R8: A transfer that brings the count to 0 raises `end_pulse` for one cycle and sets `stopped`. `stopped` stays set until `stop_clr`. A new stop event in the same cycle as `stop_clr` wins.
- R9: CPU writes use `cpu_be`: bit 1 enables bits 31:16 and bit 0 enables bits 15:0. A disabled half keeps its value.
- R10: A transfer whose step is at least the remaining nonzero count leaves the count at 0, with no wrap, and counts as reaching 0.
- R11: Synchronous active-high `rst` clears both registers, both pulses and `stopped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_cnt | input | 1 | CPU write strobe for the byte count |
| cpu_wr_blk | input | 1 | CPU write strobe for the block register |
| cpu_be | input | 2 | Half enables: bit 1 upper, bit 0 lower |
| cpu_wdata | input | 32 | CPU write data |
| stop_clr | input | 1 | Clears the stop flag |
| xfer_vld | input | 1 | One completed transfer this cycle |
| xfer_unit | input | 2 | Unit size code |
| xfer_mode | input | 2 | Transfer mode code |
| cnt_o | output | 32 | Byte count register |
| blk_o | output | 32 | Block register (reload size : running counter) |
| end_pulse | output | 1 | Count reached zero through a transfer |
| blk_pulse | output | 1 | Block boundary crossed |
| stopped | output | 1 | Channel stop indication |

## Verification
The bench targets the following corner cases:
- **Counts smaller than a word or longword step.** A design that subtracts blindly wraps to a huge count and never stops.
- **Counts exactly equal to the step.** A design that misses this case overshoots zero.
- **A zero count under traffic.** A design that does not treat zero as free-running would wrap it.
- **A CPU write that collides with the final transfer.** A design with the wrong priority either loses the write or loses the stop.
- **Block counters sitting at 1 and at 0.** A design that misses the boundary lets the counter reach zero and wrap instead of reloading.
- **Half-word writes.** A design with the enables mishandled corrupts the other half.

Random traffic with small counts and frequent collisions is compared against a bench model every cycle.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'b00,
        UNIT_WORD = 2'b01,
        UNIT_LONG = 2'b10,
        UNIT_RSVD = 2'b11
    } unit_t;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BLOCK  = 2'b01,
        MODE_REPEAT = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_t;

    localparam int BE_W = 2;

endpackage

// File: rtl/dxc_byte_count.sv
module dxc_byte_count
    import dxc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    cur,
    input  logic            xfer,
    input  unit_t           unit,
    input  logic            wr,
    input  logic [BE_W-1:0] be,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    nxt,
    output logic            hit_zero
);
    localparam int H = W / 2;

    logic [W-1:0] step;
    logic [W-1:0] dma_val;
    logic [W-1:0] cpu_val;
    logic         counting;

    always_comb begin
        unique case (unit)
            UNIT_BYTE: step = W'(1);
            UNIT_WORD: step = W'(2);
            default:   step = W'(4);
        endcase
    end

    always_comb begin
        counting = (cur != '0);
        if (!counting) begin
            dma_val = cur;
        end else if (cur <= step) begin
            dma_val = '0;
        end else begin
            dma_val = cur - step;
        end
        hit_zero = xfer && counting && (cur <= step);
    end

    always_comb begin
        cpu_val = cur;
        if (be[1]) cpu_val[W-1:H] = wdata[W-1:H];
        if (be[0]) cpu_val[H-1:0] = wdata[H-1:0];
    end

    always_comb begin
        if (wr)        nxt = cpu_val;
        else if (xfer) nxt = dma_val;
        else           nxt = cur;
    end

endmodule

// File: rtl/dxc_block_count.sv
module dxc_block_count
    import dxc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    cur,
    input  logic            xfer,
    input  mode_t           mode,
    input  logic            wr,
    input  logic [BE_W-1:0] be,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    nxt,
    output logic            boundary
);
    localparam int H = W / 2;

    logic [H-1:0] reload;
    logic [H-1:0] run;
    logic [H-1:0] run_nxt;
    logic         active;
    logic         at_edge;
    logic [W-1:0] cpu_val;

    assign reload = cur[W-1:H];
    assign run    = cur[H-1:0];

    always_comb begin
        active   = xfer && ((mode == MODE_BLOCK) || (mode == MODE_REPEAT));
        at_edge  = (run <= H'(1));
        run_nxt  = at_edge ? reload : run - H'(1);
        boundary = active && at_edge;
    end

    always_comb begin
        cpu_val = cur;
        if (be[1]) cpu_val[W-1:H] = wdata[W-1:H];
        if (be[0]) cpu_val[H-1:0] = wdata[H-1:0];
    end

    always_comb begin
        if (wr)          nxt = cpu_val;
        else if (active) nxt = {reload, run_nxt};
        else             nxt = cur;
    end

endmodule

// File: rtl/dma_xfer_counters.sv
module dma_xfer_counters
    import dxc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr_cnt,
    input  logic             cpu_wr_blk,
    input  logic [BE_W-1:0]  cpu_be,
    input  logic [CNT_W-1:0] cpu_wdata,
    input  logic             stop_clr,
    input  logic             xfer_vld,
    input  logic [1:0]       xfer_unit,
    input  logic [1:0]       xfer_mode,
    output logic [CNT_W-1:0] cnt_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             end_pulse,
    output logic             blk_pulse,
    output logic             stopped
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk;
        logic             end_p;
        logic             blk_p;
        logic             stop;
    } state_t;

    state_t state_d, state_q;

    logic [CNT_W-1:0] cnt_nxt;
    logic [BLK_W-1:0] blk_nxt;
    logic             cnt_hit;
    logic             blk_hit;

    dxc_byte_count #(.W(CNT_W)) u_cnt (
        .cur      (state_q.cnt),
        .xfer     (xfer_vld),
        .unit     (unit_t'(xfer_unit)),
        .wr       (cpu_wr_cnt),
        .be       (cpu_be),
        .wdata    (cpu_wdata),
        .nxt      (cnt_nxt),
        .hit_zero (cnt_hit)
    );

    dxc_block_count #(.W(BLK_W)) u_blk (
        .cur      (state_q.blk),
        .xfer     (xfer_vld),
        .mode     (mode_t'(xfer_mode)),
        .wr       (cpu_wr_blk),
        .be       (cpu_be),
        .wdata    (BLK_W'(cpu_wdata)),
        .nxt      (blk_nxt),
        .boundary (blk_hit)
    );

    always_comb begin
        state_d       = state_q;
        state_d.cnt   = cnt_nxt;
        state_d.blk   = blk_nxt;
        state_d.end_p = cnt_hit;
        state_d.blk_p = blk_hit;
        if (cnt_hit)       state_d.stop = 1'b1;
        else if (stop_clr) state_d.stop = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign cnt_o     = state_q.cnt;
    assign blk_o     = state_q.blk;
    assign end_pulse = state_q.end_p;
    assign blk_pulse = state_q.blk_p;
    assign stopped   = state_q.stop;

endmodule

// File: rtl/dxc_checker.sv
module dxc_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_wr_cnt,
    input logic        cpu_wr_blk,
    input logic [1:0]  cpu_be,
    input logic [31:0] cpu_wdata,
    input logic        xfer_vld,
    input logic [1:0]  xfer_unit,
    input logic [1:0]  xfer_mode,
    input logic [31:0] cnt_o,
    input logic [31:0] blk_o,
    input logic        end_pulse,
    input logic        blk_pulse,
    input logic        stopped
);
    logic blk_mode;
    assign blk_mode = (xfer_mode == 2'b01) || (xfer_mode == 2'b10);

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && !cpu_wr_cnt && xfer_unit == 2'b00 && cnt_o > 32'd1)
        |=> cnt_o == $past(cnt_o) - 32'd1); // R1

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && !cpu_wr_cnt && cnt_o == 32'd0)
        |=> (cnt_o == 32'd0 && !end_pulse)); // R2

    AST_CPU_WINS: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_cnt && cpu_be == 2'b11) |=> cnt_o == $past(cpu_wdata)); // R3

    AST_COLLIDE_STOP: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && cpu_wr_cnt && cpu_be == 2'b11 && xfer_unit == 2'b00 && cnt_o == 32'd1)
        |=> (stopped && end_pulse && cnt_o == $past(cpu_wdata))); // R4

    AST_NORMAL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && !cpu_wr_blk && !blk_mode) |=> $stable(blk_o)); // R5

    AST_RELOAD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && !cpu_wr_blk) |=> blk_o[31:16] == $past(blk_o[31:16])); // R6

    AST_BLK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && !cpu_wr_blk && blk_mode && blk_o[15:0] == 16'd1)
        |=> (blk_pulse && blk_o[15:0] == $past(blk_o[31:16]))); // R7

    AST_END_STOPS: assert property (@(posedge clk) disable iff (rst)
        end_pulse |-> stopped); // R8

endmodule

bind dma_xfer_counters dxc_checker u_dxc_checker (
    .clk        (clk),
    .rst        (rst),
    .cpu_wr_cnt (cpu_wr_cnt),
    .cpu_wr_blk (cpu_wr_blk),
    .cpu_be     (cpu_be),
    .cpu_wdata  (cpu_wdata),
    .xfer_vld   (xfer_vld),
    .xfer_unit  (xfer_unit),
    .xfer_mode  (xfer_mode),
    .cnt_o      (cnt_o),
    .blk_o      (blk_o),
    .end_pulse  (end_pulse),
    .blk_pulse  (blk_pulse),
    .stopped    (stopped)
);

// File: tb/sim_dma_xfer_counters.sv
module sim_dma_xfer_counters;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr_cnt = 1'b0;
    logic        cpu_wr_blk = 1'b0;
    logic [1:0]  cpu_be = 2'b00;
    logic [31:0] cpu_wdata = '0;
    logic        stop_clr = 1'b0;
    logic        xfer_vld = 1'b0;
    logic [1:0]  xfer_unit = 2'b00;
    logic [1:0]  xfer_mode = 2'b00;
    logic [31:0] cnt_o;
    logic [31:0] blk_o;
    logic        end_pulse;
    logic        blk_pulse;
    logic        stopped;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_cnt = '0;
    logic [31:0] m_blk = '0;
    logic        m_stop = 1'b0;

    always #5 clk = ~clk;

    dma_xfer_counters u0 (
        .clk(clk), .rst(rst), .cpu_wr_cnt(cpu_wr_cnt), .cpu_wr_blk(cpu_wr_blk),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .stop_clr(stop_clr),
        .xfer_vld(xfer_vld), .xfer_unit(xfer_unit), .xfer_mode(xfer_mode),
        .cnt_o(cnt_o), .blk_o(blk_o), .end_pulse(end_pulse),
        .blk_pulse(blk_pulse), .stopped(stopped)
    );

    function automatic logic [31:0] half_merge(logic [31:0] cur, logic [31:0] wd, logic [1:0] be);
        logic [31:0] r = cur;
        if (be[1]) r[31:16] = wd[31:16];
        if (be[0]) r[15:0]  = wd[15:0];
        return r;
    endfunction

    function automatic logic [31:0] unit_step(logic [1:0] u);
        return (u == 2'b00) ? 32'd1 : (u == 2'b01) ? 32'd2 : 32'd4;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, bit wc, bit wb, logic [1:0] be, logic [31:0] wd,
                       bit xv, logic [1:0] un, logic [1:0] md, bit clr);
        logic [31:0] st, e_cnt, e_blk;
        logic        e_end, e_bp, act;
        cpu_wr_cnt = wc; cpu_wr_blk = wb; cpu_be = be; cpu_wdata = wd;
        xfer_vld = xv; xfer_unit = un; xfer_mode = md; stop_clr = clr;
        st    = unit_step(un);
        e_end = xv && m_cnt != 0 && m_cnt <= st;
        if (wc)                   e_cnt = half_merge(m_cnt, wd, be);
        else if (xv && m_cnt != 0) e_cnt = (m_cnt <= st) ? 32'd0 : m_cnt - st;
        else                      e_cnt = m_cnt;
        act  = xv && (md == 2'b01 || md == 2'b10);
        e_bp = act && m_blk[15:0] <= 16'd1;
        if (wb)       e_blk = half_merge(m_blk, wd, be);
        else if (act) e_blk = {m_blk[31:16], e_bp ? m_blk[31:16] : m_blk[15:0] - 16'd1};
        else          e_blk = m_blk;
        m_stop = e_end ? 1'b1 : (clr ? 1'b0 : m_stop);
        m_cnt = e_cnt; m_blk = e_blk;
        @(posedge clk); #1;
        chk(tag, "cnt", cnt_o, e_cnt);
        chk(tag, "blk", blk_o, e_blk);
        chk(tag, "end_pulse", 32'(end_pulse), 32'(e_end));
        chk(tag, "blk_pulse", 32'(blk_pulse), 32'(e_bp));
        chk(tag, "stopped", 32'(stopped), 32'(m_stop));
        cpu_wr_cnt = 0; cpu_wr_blk = 0; xfer_vld = 0; stop_clr = 0;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "cnt", cnt_o, 0);
        chk("R11", "blk", blk_o, 0);
        chk("R11", "flags", {29'd0, end_pulse, blk_pulse, stopped}, 0);
        rst = 0;

        cyc("R9",  1, 0, 2'b11, 32'd100, 0, 0, 0, 0);
        cyc("R1",  0, 0, 2'b00, 0, 1, 2'b00, 0, 0);      // 99
        cyc("R1",  0, 0, 2'b00, 0, 1, 2'b01, 0, 0);      // 97
        cyc("R1",  0, 0, 2'b00, 0, 1, 2'b10, 0, 0);      // 93
        cyc("R1",  0, 0, 2'b00, 0, 1, 2'b11, 0, 0);      // 89
        cyc("R9",  1, 0, 2'b10, 32'hABCD_FFFF, 0, 0, 0, 0);
        cyc("R9",  1, 0, 2'b01, 32'hFFFF_0007, 0, 0, 0, 0);
        cyc("R2",  1, 0, 2'b11, 32'd0, 0, 0, 0, 0);
        cyc("R2",  0, 0, 2'b00, 0, 1, 2'b10, 0, 0);
        cyc("R10", 1, 0, 2'b11, 32'd3, 0, 0, 0, 0);
        cyc("R10", 0, 0, 2'b00, 0, 1, 2'b10, 0, 0);      // clamp, end, stop
        cyc("R8",  0, 0, 2'b00, 0, 0, 0, 0, 0);          // stop held
        cyc("R8",  0, 0, 2'b00, 0, 0, 0, 0, 1);          // cleared
        cyc("R8",  1, 0, 2'b11, 32'd4, 0, 0, 0, 0);
        cyc("R8",  0, 0, 2'b00, 0, 1, 2'b10, 0, 1);      // set wins over clear
        cyc("R4",  1, 0, 2'b11, 32'd2, 0, 0, 0, 1);
        cyc("R4",  1, 0, 2'b11, 32'h55, 1, 2'b01, 0, 0); // collide at zero
        cyc("R3",  1, 0, 2'b11, 32'h200, 1, 2'b00, 0, 0);
        cyc("R6",  0, 1, 2'b11, 32'h0003_0002, 0, 0, 0, 0);
        cyc("R6",  0, 0, 2'b00, 0, 1, 0, 2'b01, 0);      // lo 1
        cyc("R7",  0, 0, 2'b00, 0, 1, 0, 2'b01, 0);      // reload 3
        cyc("R5",  0, 0, 2'b00, 0, 1, 0, 2'b00, 0);
        cyc("R5",  0, 0, 2'b00, 0, 1, 0, 2'b11, 0);
        cyc("R6",  0, 0, 2'b00, 0, 1, 0, 2'b10, 0);
        cyc("R7",  0, 1, 2'b01, 32'h0, 0, 0, 0, 0);
        cyc("R7",  0, 0, 2'b00, 0, 1, 0, 2'b10, 0);      // lo 0 reloads
        cyc("R3",  0, 1, 2'b11, 32'h0009_0001, 1, 0, 2'b01, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            wd = ($urandom % 2) ? ($urandom % 9) : $urandom;
            if ($urandom % 2) wd[31:16] = 16'($urandom % 4);
            cyc("R1 R3 R4 R7 R10 random",
                ($urandom % 8) == 0, ($urandom % 8) == 0, 2'($urandom),
                wd, ($urandom % 2) == 0, 2'($urandom), 2'($urandom),
                ($urandom % 16) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule